// File: doc/BRIEF.md
# Banked internal data memory decoder

This block implements the 256-byte internal data space of an 8-bit microcontroller. A single access port carries an 8-bit address, an access kind, write data and a write enable. The block decides from the access kind and the address whether the byte lives in lower RAM, in upper RAM, or behind the special-function-register (SFR) port. The SFR contents are held outside the block and are reached through a combinational request/response port.

Two more access kinds sit on top of plain byte access. A register access names R0 to R7. The block relocates that name into one of four eight-byte banks, chosen by the 2-bit bank select that comes from the status word. A bit access takes a bit address. Bit addresses below 80h fold onto the 16-byte bit window at 20h to 2Fh. Bit addresses from 80h upward reach the eight-bit-aligned SFR byte. A bit write is a single-cycle read-modify-write that changes only the addressed bit.

Reads are combinational from registered storage. Writes land on the rising clock edge. RAM contents are not reset.

Top module: `idata_router`

## Requirements
- R1: Access kind 2'b00 (direct) with addr_i in 00h-7Fh reads and writes lower RAM byte addr_i and leaves sfr_req_o low.
- R2: Access kind 2'b01 (indirect) never raises sfr_req_o. Addresses 00h-7Fh use lower RAM and 80h-FFh use upper RAM.
- R3: Direct access with addr_i in 80h-FFh raises sfr_req_o and sets sfr_addr_o = addr_i, sfr_we_o = we_i and sfr_wdata_o = wdata_i. rdata_o returns sfr_rdata_i.
- R4: Access kind 2'b10 (register) with Rn in addr_i[2:0] uses lower RAM byte {3'b000, bank_i, n}. Bank code 00 selects 00h-07h, 01 selects 08h-0Fh, 10 selects 10h-17h and 11 selects 18h-1Fh.
- R5: Access kind 2'b11 (bit) with a bit address b in 00h-7Fh targets byte 20h + b[6:3] at bit position b[2:0]. rdata_o[0] carries the bit and rdata_o[7:1] reads zero.
- R6: A bit write stores wdata_i[0] into the addressed bit and leaves the other seven bits of the byte unchanged.
- R7: A bit access with b in 80h-FFh raises sfr_req_o with sfr_addr_o = {b[7:3], 3'b000}. On a write, sfr_wdata_o equals sfr_rdata_i with bit b[2:0] replaced by wdata_i[0].
- R8: Upper RAM and the SFR space share addresses but are separate storage. An indirect write at 80h-FFh is not visible to a direct read at the same address, and a direct write there does not change upper RAM.
- R9: A write becomes visible on the rising clock edge. In the cycle of the write, rdata_o still shows the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (checks only; storage is not reset) |
| kind_i | input | 2 | Access kind: 00 direct, 01 indirect, 10 register, 11 bit |
| addr_i | input | 8 | Byte address, register number in [2:0], or bit address |
| bank_i | input | 2 | Register bank select from the status word |
| we_i | input | 1 | Write enable |
| wdata_i | input | 8 | Write data; bit writes use bit 0 |
| rdata_o | output | 8 | Read data; bit reads return the bit in bit 0 |
| sfr_req_o | output | 1 | Access targets the SFR space |
| sfr_we_o | output | 1 | SFR write strobe |
| sfr_addr_o | output | 8 | SFR byte address |
| sfr_wdata_o | output | 8 | SFR write data (merged byte for bit writes) |
| sfr_rdata_i | input | 8 | SFR read data for sfr_addr_o |

## Verification
Some properties are checked on every cycle by the assertions:
- The routing rules: indirect accesses never reach the SFR port, and direct accesses reach it exactly in the upper half.
- Register accesses stay inside the selected bank.
- Low bit addresses land in the 20h-2Fh window.
- SFR bit writes differ from the read byte only in the addressed bit.
- Masked RAM writes change only masked bits and store the intended value.

Other properties depend on the stored contents over a sequence of accesses, so only the bench scenarios can show them:
- Upper RAM and the SFR space are kept apart at the same address.
- Data written through one access kind reads back correctly through another, for example a register write read by direct or bit access.
- A read in the same cycle as a write returns the old data.

// File: rtl/idata_pkg.sv
package idata_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 8;

  typedef enum logic [1:0] {
    ACC_DIRECT   = 2'b00,
    ACC_INDIRECT = 2'b01,
    ACC_REG      = 2'b10,
    ACC_BIT      = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    TGT_LOW = 2'b00,
    TGT_UP  = 2'b01,
    TGT_SFR = 2'b10
  } tgt_e;
endpackage

// File: rtl/idata_decode.sv
module idata_decode
  import idata_pkg::*;
#(
  parameter logic [AW-1:0] BIT_BASE = 8'h20
) (
  input  acc_kind_e      kind_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [1:0]     bank_i,
  output tgt_e           tgt_o,
  output logic [AW-1:0]  byte_addr_o,
  output logic           bit_op_o,
  output logic [2:0]     bit_idx_o
);
  always_comb begin
    tgt_o       = TGT_LOW;
    byte_addr_o = addr_i;
    bit_op_o    = 1'b0;
    bit_idx_o   = 3'd0;
    unique case (kind_i)
      ACC_DIRECT:   tgt_o = addr_i[AW-1] ? TGT_SFR : TGT_LOW;
      ACC_INDIRECT: tgt_o = addr_i[AW-1] ? TGT_UP  : TGT_LOW;
      ACC_REG:      byte_addr_o = {3'b000, bank_i, addr_i[2:0]};
      ACC_BIT: begin
        bit_op_o  = 1'b1;
        bit_idx_o = addr_i[2:0];
        if (addr_i[AW-1]) begin
          tgt_o       = TGT_SFR;
          byte_addr_o = {addr_i[AW-1:3], 3'b000};
        end else begin
          byte_addr_o = BIT_BASE + {4'b0000, addr_i[6:3]};
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/idata_ram.sv
module idata_ram #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 128,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] addr_i,
  input  logic [DW-1:0] mask_i,
  input  logic [DW-1:0] wbits_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= (mem[addr_i] & ~mask_i) | (wbits_i & mask_i);
  end

  assign rdata_o = mem[addr_i];

  // R6: unmasked bits survive a write
  p_keep_unmasked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((mem[$past(addr_i)] ^ $past(mem[addr_i])) & ~$past(mask_i)) == '0);
  // R9: masked bits hold the written value after the edge
  p_write_lands_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((mem[$past(addr_i)] ^ $past(wbits_i)) & $past(mask_i)) == '0);
endmodule

// File: rtl/idata_router.sv
module idata_router
  import idata_pkg::*;
#(
  parameter logic [AW-1:0] BIT_BASE = 8'h20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    kind_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    bank_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          sfr_req_o,
  output logic          sfr_we_o,
  output logic [AW-1:0] sfr_addr_o,
  output logic [DW-1:0] sfr_wdata_o,
  input  logic [DW-1:0] sfr_rdata_i
);
  localparam int unsigned HALF = 2 ** (AW - 1);

  acc_kind_e     kind;
  tgt_e          tgt;
  logic [AW-1:0] byte_addr;
  logic          bit_op;
  logic [2:0]    bit_idx;
  logic [DW-1:0] mask, wbits, sel_byte;
  logic [DW-1:0] ram_rd [2];

  assign kind = acc_kind_e'(kind_i);

  idata_decode #(.BIT_BASE(BIT_BASE)) u_dec (
    .kind_i(kind), .addr_i(addr_i), .bank_i(bank_i),
    .tgt_o(tgt), .byte_addr_o(byte_addr), .bit_op_o(bit_op), .bit_idx_o(bit_idx)
  );

  assign mask  = bit_op ? (DW'(1) << bit_idx) : '1;
  assign wbits = bit_op ? {DW{wdata_i[0]}} : wdata_i;

  // index 0: lower half, index 1: upper half (indirect only)
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic hit;
    assign hit = (h == 0) ? (tgt == TGT_LOW) : (tgt == TGT_UP);
    idata_ram #(.DW(DW), .DEPTH(HALF)) u_ram (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i && hit),
      .addr_i(byte_addr[AW-2:0]), .mask_i(mask), .wbits_i(wbits),
      .rdata_o(ram_rd[h])
    );
  end

  assign sfr_req_o   = (tgt == TGT_SFR);
  assign sfr_we_o    = sfr_req_o && we_i;
  assign sfr_addr_o  = byte_addr;
  assign sfr_wdata_o = (sfr_rdata_i & ~mask) | (wbits & mask);

  assign sel_byte = sfr_req_o ? sfr_rdata_i : ram_rd[tgt == TGT_UP];
  assign rdata_o  = bit_op ? {{(DW-1){1'b0}}, sel_byte[bit_idx]} : sel_byte;

  p_direct_low_ram_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == 2'b00 && !addr_i[AW-1]) |-> !sfr_req_o);
  p_indirect_no_sfr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == 2'b01) |-> !sfr_req_o);
  p_direct_high_sfr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == 2'b00 && addr_i[AW-1]) |->
      (sfr_req_o && sfr_addr_o == addr_i && sfr_we_o == we_i && sfr_wdata_o == wdata_i));
  p_reg_in_bank_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == 2'b10) |-> (byte_addr[AW-1:5] == '0 && byte_addr[4:3] == bank_i));
  p_bit_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == 2'b11 && !addr_i[AW-1]) |->
      (byte_addr[AW-1:4] == BIT_BASE[AW-1:4] && rdata_o[DW-1:1] == '0));
  p_sfr_bit_merge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == 2'b11 && addr_i[AW-1] && we_i) |->
      (sfr_we_o && ((sfr_wdata_o ^ sfr_rdata_i) & ~(DW'(1) << addr_i[2:0])) == '0));
endmodule

// File: tb/idata_router_tb.sv
`timescale 1ns/1ps
module idata_router_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] kind_i = 2'b01;
  logic [7:0] addr_i = '0;
  logic [1:0] bank_i = '0;
  logic       we_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o, sfr_addr_o, sfr_wdata_o, sfr_rdata_i;
  logic       sfr_req_o, sfr_we_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] ref_mem [256];

  always #2.5 clk_i = ~clk_i;

  assign sfr_rdata_i = sfr_addr_o ^ 8'hA5;

  idata_router u_dut (.*);

  function automatic logic [7:0] sfr_val(input logic [7:0] a);
    return a ^ 8'hA5;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [1:0] k, input logic [7:0] a,
                                        input logic [1:0] b);
    logic [7:0] v;
    case (k)
      2'b00:   v = a[7] ? sfr_val(a) : ref_mem[a];
      2'b01:   v = ref_mem[a];
      2'b10:   v = ref_mem[{3'b000, b, a[2:0]}];
      default: begin
        v = a[7] ? sfr_val({a[7:3], 3'b000}) : ref_mem[8'h20 + {4'h0, a[6:3]}];
        v = {7'b0, v[a[2:0]]};
      end
    endcase
    return v;
  endfunction

  function automatic string req_of(input logic [1:0] k, input logic [7:0] a,
                                   input logic w);
    case (k)
      2'b00:   return a[7] ? "R3" : "R1";
      2'b01:   return "R2";
      2'b10:   return "R4";
      default: return a[7] ? "R7" : (w ? "R6" : "R5");
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [7:0] act,
                     input logic [7:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] k, input logic [7:0] a, input logic [1:0] b,
                       input logic w, input logic [7:0] d, input bit check);
    logic [7:0] e, sa, sw;
    logic       sreq;
    string      rq;
    @(negedge clk_i);
    kind_i = k; addr_i = a; bank_i = b; we_i = w; wdata_i = d;
    #1;
    rq   = req_of(k, a, w);
    sreq = (k == 2'b00 && a[7]) || (k == 2'b11 && a[7]);
    sa   = (k == 2'b11) ? {a[7:3], 3'b000} : a;
    if (check) begin
      e = exp_rd(k, a, b);
      chk(rdata_o === e, rq, rdata_o, e);
      chk(sfr_req_o === sreq, rq, {7'b0, sfr_req_o}, {7'b0, sreq});
      if (sreq) begin
        chk(sfr_addr_o === sa, rq, sfr_addr_o, sa);
        chk(sfr_we_o === w, rq, {7'b0, sfr_we_o}, {7'b0, w});
        if (w) begin
          sw = d;
          if (k == 2'b11) begin
            sw = sfr_val(sa);
            sw[a[2:0]] = d[0];
          end
          chk(sfr_wdata_o === sw, rq, sfr_wdata_o, sw);
        end
      end
    end
    @(posedge clk_i);
    if (w && !sreq) begin
      case (k)
        2'b00, 2'b01: ref_mem[a] = d;
        2'b10:        ref_mem[{3'b000, b, a[2:0]}] = d;
        default:      ref_mem[8'h20 + {4'h0, a[6:3]}][a[2:0]] = d[0];
      endcase
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk_i);
    #1;
    chk(sfr_req_o === 1'b0, "reset R2", {7'b0, sfr_req_o}, 8'h00);
    rst_ni = 1'b1;
    // fill the whole RAM through indirect access
    for (int i = 0; i < 256; i++) do_op(2'b01, 8'(i), 2'b00, 1'b1, 8'(i * 7 + 3), 1'b0);
    for (int i = 0; i < 256; i += 17) do_op(2'b01, 8'(i), 2'b00, 1'b0, 8'h00, 1'b1);

    // R8: upper RAM and SFR space at the same address are separate
    do_op(2'b01, 8'h90, 2'b00, 1'b1, 8'h33, 1'b1);
    do_op(2'b00, 8'h90, 2'b00, 1'b0, 8'h00, 1'b1);
    chk(rdata_o === 8'h35, "R8 direct sees SFR", rdata_o, 8'h35);
    do_op(2'b00, 8'h90, 2'b00, 1'b1, 8'hEE, 1'b1);
    do_op(2'b01, 8'h90, 2'b00, 1'b0, 8'h00, 1'b1);
    chk(rdata_o === 8'h33, "R8 upper RAM kept", rdata_o, 8'h33);

    // R9: old data during the write cycle, new data afterwards
    do_op(2'b00, 8'h45, 2'b00, 1'b1, 8'h5C, 1'b1);
    do_op(2'b00, 8'h45, 2'b00, 1'b0, 8'h00, 1'b1);
    chk(rdata_o === 8'h5C, "R9 write visible", rdata_o, 8'h5C);

    // R4: each bank maps R7 to its own byte
    for (int b = 0; b < 4; b++) do_op(2'b10, 8'h07, 2'(b), 1'b1, 8'(8'hB0 + b), 1'b1);
    for (int b = 0; b < 4; b++) begin
      do_op(2'b00, 8'(b * 8 + 7), 2'b00, 1'b0, 8'h00, 1'b1);
      chk(rdata_o === 8'(8'hB0 + b), "R4 bank byte", rdata_o, 8'(8'hB0 + b));
    end

    // R5/R6: corner bits 00h and 7Fh
    do_op(2'b00, 8'h20, 2'b00, 1'b1, 8'h00, 1'b1);
    do_op(2'b11, 8'h00, 2'b00, 1'b1, 8'h01, 1'b1);
    do_op(2'b00, 8'h2F, 2'b00, 1'b1, 8'hFF, 1'b1);
    do_op(2'b11, 8'h7F, 2'b00, 1'b1, 8'h00, 1'b1);
    do_op(2'b00, 8'h20, 2'b00, 1'b0, 8'h00, 1'b1);
    chk(rdata_o === 8'h01, "R6 bit 00h", rdata_o, 8'h01);
    do_op(2'b00, 8'h2F, 2'b00, 1'b0, 8'h00, 1'b1);
    chk(rdata_o === 8'h7F, "R6 bit 7Fh", rdata_o, 8'h7F);

    // R7: SFR bit write merges into the read byte
    do_op(2'b11, 8'hD3, 2'b01, 1'b1, 8'h01, 1'b1);

    // random mix
    for (int n = 0; n < 3000; n++)
      do_op(2'($urandom), 8'($urandom), 2'($urandom), 1'($urandom), 8'($urandom), 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule